// File: doc/BRIEF.md
# I2C Register Slave Front End

This block lets an external I2C master read and write a bank of internal control registers. It watches the bus clock and data lines through a synchroniser in the fast system clock domain. It detects START and STOP conditions and recognises its own 7-bit device address. The lowest bit of that address comes from a strap pin that is captured while reset is asserted.

After the device address, a write carries one register sub-address byte and then any number of data bytes. Each data byte produces a one-cycle write strobe, and the register address steps up by one after each byte. A read normally follows a sub-address write, a repeated START and the device address with the read bit set. The block then requests register data and shifts it out MSB first, one byte per master acknowledge. The data line is driven open-drain through a single pull-low output.

Top module: `i2c_reg_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START. It begins device-address reception from any state, including partway through a byte, so a repeated START restarts the transfer.
- R2: A rising SDA while SCL is high is a STOP. It releases SDA, returns the block to idle and suppresses all strobes until the next START.
- R3: The block matches the 7-bit address 0110000 when `addr_strap` was low during reset and 0110001 when it was high. Changes on the pin after reset have no effect. On a match it pulls SDA low during the 9th clock, whichever way the R/W bit (8th bit, 1 = read) points.
- R4: A non-matching address gets no acknowledge. The block then raises no strobes and pulls SDA on no later byte until the next START or STOP.
- R5: In a write, the byte after the device address sets the register address. Each following byte, received MSB first, raises `wr_en` for one cycle with `reg_addr` equal to the current register address and `wr_data` equal to the byte, and each byte is acknowledged.
- R6: Within a write burst the register address increments after every data byte and wraps from 255 to 0.
- R7: After the device address with R/W = 1, `rd_en` pulses with `reg_addr` set. `rd_data` is taken in the following cycle and shifted out MSB first. SDA drive changes only while SCL is low.
- R8: In a read, a master ACK (SDA low on the 9th clock) advances the address by one with wrap and requests the next byte. A master NACK releases SDA and requests nothing more, so a burst of n bytes gives exactly n `rd_en` pulses.
- R9: `wr_en` and `rd_en` are each single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_strap | input | 1 | Device address LSB, captured during reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| reg_addr | output | AW | Register address for write and read requests |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_data | output | 8 | Write data, valid with `wr_en` |
| rd_en | output | 1 | One-cycle register read request |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |

## Verification
Single-byte writes and reads at fixed addresses show the basic byte framing and acknowledge timing. Bursts that start near the top of the address space separate correct wrap-around from a saturating or non-incrementing address. Foreign device addresses and an aborted byte followed by a repeated START show whether stray bus traffic reaches the registers. Randomly sized read and write bursts at random sub-addresses, under both strap settings, compare every returned byte and every strobe count against a bench register model.

// File: rtl/i2cs_pkg.sv
// Shared types for the I2C register slave.
// Assumes: one bus event at most is of interest per system clock cycle.
package i2cs_pkg;

    // Protocol phases of the slave controller
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } bus_st_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        BK_DEV,
        BK_SUB,
        BK_DATA
    } byte_kind_t;

    // Bus events decoded in the system clock domain
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2cs_sync.sv
// Multi-stage synchroniser for asynchronous bus lines.
// Assumes: lines idle high, so the chain resets to all ones.
module i2cs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the raw levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain[0] <= d_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_out = chain[STAGES-1];

endmodule

// File: rtl/i2cs_cond.sv
// Bus condition decoder: START, STOP and SCL edges from synchronised lines.
// Assumes: inputs are already synchronous to clk.
module i2cs_cond
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    // Remember the previous line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Classify the current cycle
    always_comb begin
        ev.start = scl_q & scl_s & sda_q & ~sda_s;
        ev.stop  = scl_q & scl_s & ~sda_q & sda_s;
        ev.rise  = ~scl_q & scl_s;
        ev.fall  = scl_q & ~scl_s;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/i2cs_ctrl.sv
// Slave protocol controller: address match, sub-address, burst write and
// burst read with auto-increment, acknowledge and open-drain data drive.
// Assumes: SCL is slow enough that several clk cycles separate its edges;
// rd_data is valid one cycle after rd_en.
module i2cs_ctrl
    import i2cs_pkg::*;
#(
    parameter int         AW     = 8,
    parameter logic [5:0] DEV_HI = 6'b011000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap,
    input  bus_ev_t       ev,
    input  logic [7:0]    rd_data,
    output logic          sda_pull,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          rd_en,
    output logic [AW-1:0] reg_addr,
    output bus_st_t       st
);

    localparam logic [AW-1:0] ADDR_ONE = AW'(1);
    localparam logic [3:0]    LAST_BIT = 4'd7;
    localparam logic [3:0]    BYTE_END = 4'd8;

    byte_kind_t    kind;
    logic          strap_q;
    logic [3:0]    cnt;
    logic [6:0]    rx_sh;
    logic [7:0]    tx_sh;
    logic          rnw;
    logic          ack_seen;
    logic          rd_fill;
    logic [AW-1:0] addr;
    logic [7:0]    rx_byte;
    logic          dev_hit;

    assign rx_byte  = {rx_sh, ev.sda};
    assign dev_hit  = (rx_byte[7:1] == {DEV_HI, strap_q});
    assign reg_addr = addr;

    // Capture the address strap only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap;
        end
    end

    // Protocol state machine and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            kind     <= BK_DEV;
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            rnw      <= 1'b0;
            ack_seen <= 1'b0;
            rd_fill  <= 1'b0;
            addr     <= '0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
            rd_en    <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            rd_en   <= 1'b0;
            rd_fill <= rd_en;
            if (rd_fill) begin
                tx_sh <= rd_data;
            end
            if (ev.start) begin
                st       <= ST_RX;
                kind     <= BK_DEV;
                cnt      <= '0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                st       <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.rise && cnt < BYTE_END) begin
                            rx_sh <= rx_byte[6:0];
                            cnt   <= cnt + 4'd1;
                            if (cnt == LAST_BIT) begin
                                case (kind)
                                    BK_DEV: begin
                                        if (dev_hit) begin
                                            rnw   <= rx_byte[0];
                                            rd_en <= rx_byte[0];
                                        end else begin
                                            st <= ST_WAIT;
                                        end
                                    end
                                    BK_SUB: addr <= rx_byte[AW-1:0];
                                    default: begin
                                        wr_en   <= 1'b1;
                                        wr_data <= rx_byte;
                                    end
                                endcase
                            end
                        end else if (ev.fall && cnt == BYTE_END) begin
                            st       <= ST_RX_ACK;
                            sda_pull <= 1'b1;
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.fall) begin
                            sda_pull <= 1'b0;
                            cnt      <= '0;
                            case (kind)
                                BK_DEV: begin
                                    if (rnw) begin
                                        st       <= ST_TX;
                                        sda_pull <= ~tx_sh[7];
                                    end else begin
                                        st   <= ST_RX;
                                        kind <= BK_SUB;
                                    end
                                end
                                BK_SUB: begin
                                    st   <= ST_RX;
                                    kind <= BK_DATA;
                                end
                                default: begin
                                    st   <= ST_RX;
                                    addr <= addr + ADDR_ONE;
                                end
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (ev.fall) begin
                            cnt   <= cnt + 4'd1;
                            tx_sh <= {tx_sh[6:0], 1'b0};
                            if (cnt == LAST_BIT) begin
                                sda_pull <= 1'b0;
                                st       <= ST_TX_ACK;
                            end else begin
                                sda_pull <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.rise) begin
                            ack_seen <= ~ev.sda;
                            if (ev.sda) begin
                                st <= ST_WAIT;
                            end else begin
                                addr  <= addr + ADDR_ONE;
                                rd_en <= 1'b1;
                            end
                        end else if (ev.fall && ack_seen) begin
                            st       <= ST_TX;
                            cnt      <= '0;
                            ack_seen <= 1'b0;
                            sda_pull <= ~tx_sh[7];
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_reg_slave.sv
// I2C register slave top: synchroniser, condition decoder, controller.
// Assumes: sda_pull drives an external open-drain pad; clk is far faster
// than SCL; the register bank answers rd_en one cycle later on rd_data.
module i2c_reg_slave #(
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_HI      = 6'b011000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_strap,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_pull,
    output logic [AW-1:0] reg_addr,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          rd_en,
    input  logic [7:0]    rd_data
);

    logic                  scl_s;
    logic                  sda_s;
    i2cs_pkg::bus_ev_t     bus_ev;
    i2cs_pkg::bus_st_t     bus_st;

    i2cs_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_i, sda_i}),
        .q_out ({scl_s, sda_s})
    );

    i2cs_cond u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .ev    (bus_ev)
    );

    i2cs_ctrl #(
        .AW     (AW),
        .DEV_HI (DEV_HI)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap    (addr_strap),
        .ev       (bus_ev),
        .rd_data  (rd_data),
        .sda_pull (sda_pull),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .reg_addr (reg_addr),
        .st       (bus_st)
    );

endmodule

// File: rtl/i2cs_chk.sv
// Protocol checker for the I2C register slave, bound to the top module.
// Assumes: sampled on clk with the same synchronous reset.
module i2cs_chk
    import i2cs_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input bus_ev_t ev,
    input bus_st_t st,
    input logic    scl_s,
    input logic    sda_pull,
    input logic    wr_en,
    input logic    rd_en
);

    AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s); // R7

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop |=> (!sda_pull && st == ST_IDLE)); // R2

    AST_IGNORED_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> !sda_pull); // R4

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R9

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en); // R9

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en)); // R9

endmodule

bind i2c_reg_slave i2cs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (bus_ev),
    .st       (bus_st),
    .scl_s    (scl_s),
    .sda_pull (sda_pull),
    .wr_en    (wr_en),
    .rd_en    (rd_en)
);

// File: tb/test_i2c_reg_slave.sv
`timescale 1ns/1ps
// Bench: bus-level master tasks, register bank model, random and directed traffic.
module test_i2c_reg_slave;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_strap = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic [7:0] reg_addr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       rd_en;
    logic [7:0] rd_data;
    wire        sda_line = sda_m & ~sda_pull;

    logic [7:0] bank  [256];
    logic [7:0] model [256];
    logic [7:0] pay   [16];
    logic [7:0] got   [16];
    int wr_cnt = 0, rd_cnt = 0, ovl_cnt = 0, drv_viol = 0;
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic pull_q = 1'b0;

    always #2.5 clk = ~clk;

    i2c_reg_slave i_i2c_reg_slave (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
        .scl_i(scl_m), .sda_i(sda_line), .sda_pull(sda_pull),
        .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 29 + 7);
    endfunction

    // Register bank served to the slave, plus pulse monitors
    always @(posedge clk) begin
        rd_data <= bank[reg_addr];
        pull_q  <= sda_pull;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bank[i] <= init_val(i);
        end else begin
            if (wr_en) begin
                bank[reg_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (rd_en) rd_cnt <= rd_cnt + 1;
            if (wr_en && rd_en) ovl_cnt <= ovl_cnt + 1;
            if (sda_pull != pull_q && scl_m) drv_viol <= drv_viol + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q / 2);
        b = sda_line; tick(Q - Q / 2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic rd_byte(input bit m_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!m_ack);
    endtask

    // Write burst; returns number of acknowledged bytes
    task automatic do_write(input logic [6:0] dev, input logic [7:0] sub,
                            input int n, output int acks);
        bit a;
        acks = 0;
        bus_start();
        wr_byte({dev, 1'b0}, a); acks += int'(a);
        wr_byte(sub, a);         acks += int'(a);
        for (int k = 0; k < n; k++) begin
            wr_byte(pay[k], a); acks += int'(a);
        end
        bus_stop();
    endtask

    // Sub-address write, repeated START, read burst ending with NACK
    task automatic do_read(input logic [6:0] dev, input logic [7:0] sub,
                           input int n, output int acks);
        bit a;
        acks = 0;
        bus_start();
        wr_byte({dev, 1'b0}, a); acks += int'(a);
        wr_byte(sub, a);         acks += int'(a);
        bus_start();
        wr_byte({dev, 1'b1}, a); acks += int'(a);
        for (int k = 0; k < n; k++) rd_byte(k != n - 1, got[k]);
        bus_stop();
    endtask

    task automatic apply_reset(input logic strap);
        rst_n = 1'b0; addr_strap = strap; scl_m = 1'b1; sda_m = 1'b1;
        tick(6);
        rst_n = 1'b1;
        tick(4);
        for (int i = 0; i < 256; i++) model[i] = init_val(i);
    endtask

    // Write with model update and checks on acks and strobe count
    task automatic write_checked(input logic [6:0] dev, input logic [7:0] sub,
                                 input int n, input string req);
        int acks, w0;
        w0 = wr_cnt;
        do_write(dev, sub, n, acks);
        chk(acks == n + 2, req, "write acks", acks, n + 2);
        chk(wr_cnt - w0 == n, req, "write strobes", wr_cnt - w0, n);
        for (int k = 0; k < n; k++) model[8'(sub + k)] = pay[k];
    endtask

    task automatic read_checked(input logic [6:0] dev, input logic [7:0] sub,
                                input int n, input string req);
        int acks, r0;
        r0 = rd_cnt;
        do_read(dev, sub, n, acks);
        chk(acks == 3, req, "read acks", acks, 3);
        chk(rd_cnt - r0 == n, "R8", "read requests", rd_cnt - r0, n);
        for (int k = 0; k < n; k++)
            chk(got[k] == model[8'(sub + k)], req, "read byte", got[k], model[8'(sub + k)]);
    endtask

    initial begin
        int acks, w0, r0, n;
        logic [7:0] sub;
        bit a;
        void'($urandom(32'h5eed_2121));
        apply_reset(1'b0);
        // R2: idle after reset
        chk(!sda_pull && !wr_en && !rd_en, "R2", "reset outputs",
            {sda_pull, wr_en, rd_en}, 0);

        // R3 R5 R7: single write then single read
        pay[0] = 8'hA5;
        write_checked(7'h30, 8'h10, 1, "R5");
        read_checked(7'h30, 8'h10, 1, "R7");

        // R6 R8: bursts across the wrap point
        for (int k = 0; k < 5; k++) pay[k] = 8'hC0 + 8'(k);
        write_checked(7'h30, 8'hFD, 5, "R6");
        read_checked(7'h30, 8'hFD, 5, "R8");

        // R4: foreign addresses are ignored, including later bytes
        pay[0] = 8'h11; pay[1] = 8'h22;
        w0 = wr_cnt;
        do_write(7'h31, 8'h10, 2, acks);
        chk(acks == 0, "R4", "foreign acks", acks, 0);
        do_write(7'h18, 8'h10, 2, acks);
        chk(acks == 0, "R4", "foreign acks 2", acks, 0);
        chk(wr_cnt == w0, "R4", "foreign strobes", wr_cnt - w0, 0);
        read_checked(7'h30, 8'h10, 2, "R4");

        // R1: repeated START in the middle of a data byte
        w0 = wr_cnt;
        bus_start();
        wr_byte(8'h60, a);
        wr_byte(8'h40, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        wr_byte(8'h60, a);
        chk(a, "R1", "ack after restart", a, 1);
        wr_byte(8'h41, a);
        wr_byte(8'h77, a);
        bus_stop();
        model[8'h41] = 8'h77;
        chk(wr_cnt - w0 == 1, "R1", "strobes after restart", wr_cnt - w0, 1);
        read_checked(7'h30, 8'h40, 2, "R1");

        // R2: after STOP no strobes without a new START
        w0 = wr_cnt; r0 = rd_cnt;
        for (int i = 0; i < 9; i++) put_bit(1'b0);
        sda_m = 1'b1; scl_m = 1'b1; tick(Q);
        chk(wr_cnt == w0 && rd_cnt == r0, "R2", "strobes while idle",
            wr_cnt - w0 + rd_cnt - r0, 0);

        // R5 R6 R8: random bursts
        for (int it = 0; it < 18; it++) begin
            n = 1 + int'($urandom_range(0, 5));
            sub = 8'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                for (int k = 0; k < n; k++) pay[k] = 8'($urandom);
                write_checked(7'h30, sub, n, "R6");
            end else begin
                read_checked(7'h30, sub, n, "R8");
            end
        end

        // R3: strap high selects 0110001; later pin changes are ignored
        apply_reset(1'b1);
        addr_strap = 1'b0;
        pay[0] = 8'h3C; pay[1] = 8'h4D;
        write_checked(7'h31, 8'h20, 2, "R3");
        w0 = wr_cnt;
        do_write(7'h30, 8'h20, 1, acks);
        chk(acks == 0, "R3", "low-strap address with strap high", acks, 0);
        chk(wr_cnt == w0, "R4", "strobes for wrong address", wr_cnt - w0, 0);
        read_checked(7'h31, 8'h20, 2, "R3");

        // R7 R9: drive timing and strobe exclusivity over the whole run
        chk(drv_viol == 0, "R7", "SDA drive changed with SCL high", drv_viol, 0);
        chk(ovl_cnt == 0, "R9", "wr_en and rd_en together", ovl_cnt, 0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule